// File: doc/BRIEF.md
# Hamming Sector ECC Checker

This block judges one 512-byte sector protected by a single-error-correcting Hamming code. It receives two 3-byte codes. One is the code read back from the spare area. The other is the code recomputed over the data that was just read. From these two codes it decides whether the sector is clean, whether one data bit must be flipped, whether the ECC field itself was hit, or whether the damage cannot be repaired. A freshly erased sector stores all-ones in its spare area and has all-zero computed parity. The block recognises that pattern and reports it as clean, not as a failure.

The parity generator and the sector buffer are outside the block. The surrounding logic pulses `start` with both codes valid. One clock later the block pulses `done` with a registered verdict. On a correctable error it also gives the byte index and a one-hot bit mask, and the caller XORs that mask into the buffered byte. A new `start` may arrive in every cycle.

Top module: `ham_sector_corrector`

## Requirements
- R1: Each 3-byte code (byte0 on bits 7:0, byte1 on bits 15:8, byte2 on bits 23:16 of the input) is repacked into a 32-bit word as follows: byte0 goes to bits 7:0, the low nibble of byte2 to bits 11:8, byte1 to bits 23:16, and the high nibble of byte2 to bits 27:24. All other bits are zero.
- R2: The syndrome is the XOR of the two repacked words. A zero syndrome gives status 0 (clean).
- R3: A syndrome with exactly 12 set bits gives status 1 (corrected). `fix_byte` equals syndrome bits 27:19 and `fix_mask` has only bit (syndrome bits 18:16) set.
- R4: A syndrome with exactly one set bit gives status 2 (ECC field corrupted). No data location is reported.
- R5: A syndrome of any other nonzero weight gives status 0 (erased page) when the repacked stored code is 0x0FFF0FFF and the repacked computed code is 0.
- R6: Every other nonzero syndrome gives status 3 (uncorrectable).
- R7: `done` is high for exactly one cycle, in the cycle after each `start`. The verdict outputs are valid in that cycle. A `start` in every cycle produces a `done` in every following cycle, each with the verdict of its own sector.
- R8: A synchronous active-high reset drives `done` and `status` to 0 by the next clock edge.
- R9: Whenever the reported status is not 1, `fix_byte` and `fix_mask` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Both codes are valid; begin a check |
| stored_code | input | 24 | Code read from the spare area, byte0 in the low bits |
| calc_code | input | 24 | Code recomputed over the read data, byte0 in the low bits |
| done | output | 1 | One-cycle pulse: the verdict is valid |
| status | output | 2 | 0 clean, 1 corrected, 2 ECC field bad, 3 uncorrectable |
| fix_byte | output | 9 | Byte index of the bit to flip (status 1 only) |
| fix_mask | output | 8 | One-hot mask of the bit to flip (status 1 only) |

## Verification
The registered verdict of one sector and the classification of the next can occur in the same cycle when `start` is held high for several cycles. The bench provokes this with bursts of back-to-back starts. In a burst each cycle mixes the classes, so that a correction directly follows an erased page or a corrupted ECC field. In every cycle of the burst the bench compares `status`, `fix_byte` and `fix_mask` with the verdict it predicts for the sector driven one cycle earlier. A verdict that is held over from the previous sector or leaks into the next one therefore shows up as a mismatch.

// File: rtl/ham_ecc_pkg.sv
package ham_ecc_pkg;

  localparam int CODE_W      = 24;
  localparam int WORD_W      = 32;
  localparam int SECTOR_SIZE = 512;
  localparam int IDX_W       = $clog2(SECTOR_SIZE);
  localparam int BITSEL_W    = 3;
  localparam int WEIGHT_W    = $clog2(WORD_W + 1);
  localparam int PAIR_WEIGHT = 12;
  localparam int BITSEL_LSB  = 16;
  localparam int IDX_LSB     = BITSEL_LSB + BITSEL_W;
  localparam logic [WORD_W-1:0] ERASED_WORD = 32'h0FFF_0FFF;

  typedef enum logic [1:0] {
    VERDICT_CLEAN   = 2'd0,
    VERDICT_FIXED   = 2'd1,
    VERDICT_ECC_BAD = 2'd2,
    VERDICT_UNCORR  = 2'd3
  } verdict_e;

  // Interleave the three code bytes into the comparison word.
  function automatic logic [WORD_W-1:0] pack_code(input logic [CODE_W-1:0] c);
    logic [WORD_W-1:0] w;
    w         = '0;
    w[7:0]    = c[7:0];
    w[11:8]   = c[19:16];
    w[23:16]  = c[15:8];
    w[27:24]  = c[23:20];
    return w;
  endfunction

  function automatic logic [WEIGHT_W-1:0] pop_count(input logic [WORD_W-1:0] w);
    logic [WEIGHT_W-1:0] n;
    n = '0;
    for (int i = 0; i < WORD_W; i++) n = n + WEIGHT_W'(w[i]);
    return n;
  endfunction

endpackage

// File: rtl/ham_code_repack.sv
module ham_code_repack
  import ham_ecc_pkg::*;
(
  input  logic [CODE_W-1:0] code_in,
  output logic [WORD_W-1:0] word_out
);
  always_comb word_out = pack_code(code_in);
endmodule

// File: rtl/ham_syndrome_weight.sv
module ham_syndrome_weight
  import ham_ecc_pkg::*;
(
  input  logic [WORD_W-1:0]   stored_word,
  input  logic [WORD_W-1:0]   calc_word,
  output logic [WORD_W-1:0]   syndrome,
  output logic [WEIGHT_W-1:0] weight
);
  always_comb begin
    syndrome = stored_word ^ calc_word;
    weight   = pop_count(syndrome);
  end
endmodule

// File: rtl/ham_verdict.sv
module ham_verdict
  import ham_ecc_pkg::*;
(
  input  logic [WORD_W-1:0]   syndrome,
  input  logic [WEIGHT_W-1:0] weight,
  input  logic [WORD_W-1:0]   stored_word,
  input  logic [WORD_W-1:0]   calc_word,
  output verdict_e            verdict,
  output logic [IDX_W-1:0]    loc_byte,
  output logic [7:0]          loc_mask,
  output logic                ev_clean,
  output logic                ev_pair,
  output logic                ev_single,
  output logic                ev_erased
);
  logic [BITSEL_W-1:0] bit_sel;

  always_comb begin
    ev_clean  = (syndrome == '0);
    ev_pair   = (weight == WEIGHT_W'(PAIR_WEIGHT));
    ev_single = (weight == WEIGHT_W'(1));
    ev_erased = (stored_word == ERASED_WORD) && (calc_word == '0);
    bit_sel   = syndrome[BITSEL_LSB +: BITSEL_W];
    loc_byte  = '0;
    loc_mask  = '0;
    if (ev_clean) begin
      verdict = VERDICT_CLEAN;
    end else if (ev_pair) begin
      verdict  = VERDICT_FIXED;
      loc_byte = syndrome[IDX_LSB +: IDX_W];
      loc_mask = 8'(1) << bit_sel;
    end else if (ev_single) begin
      verdict = VERDICT_ECC_BAD;
    end else if (ev_erased) begin
      verdict = VERDICT_CLEAN;
    end else begin
      verdict = VERDICT_UNCORR;
    end
  end
endmodule

// File: rtl/ham_sector_corrector.sv
module ham_sector_corrector
  import ham_ecc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [CODE_W-1:0]    stored_code,
  input  logic [CODE_W-1:0]    calc_code,
  output logic                 done,
  output logic [1:0]           status,
  output logic [IDX_W-1:0]     fix_byte,
  output logic [7:0]           fix_mask
);
  logic [WORD_W-1:0]   stored_word;
  logic [WORD_W-1:0]   calc_word;
  logic [WORD_W-1:0]   syndrome;
  logic [WEIGHT_W-1:0] syn_weight;
  verdict_e            verdict;
  logic [IDX_W-1:0]    loc_byte;
  logic [7:0]          loc_mask;
  logic                ev_clean, ev_pair, ev_single, ev_erased;

  ham_code_repack u_pack_stored (.code_in(stored_code), .word_out(stored_word));
  ham_code_repack u_pack_calc   (.code_in(calc_code),   .word_out(calc_word));

  ham_syndrome_weight u_weight (
    .stored_word(stored_word), .calc_word(calc_word),
    .syndrome(syndrome), .weight(syn_weight)
  );

  ham_verdict u_verdict (
    .syndrome(syndrome), .weight(syn_weight),
    .stored_word(stored_word), .calc_word(calc_word),
    .verdict(verdict), .loc_byte(loc_byte), .loc_mask(loc_mask),
    .ev_clean(ev_clean), .ev_pair(ev_pair),
    .ev_single(ev_single), .ev_erased(ev_erased)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done     <= 1'b0;
      status   <= VERDICT_CLEAN;
      fix_byte <= '0;
      fix_mask <= '0;
    end else begin
      done <= start;
      if (start) begin
        status   <= verdict;
        fix_byte <= loc_byte;
        fix_mask <= loc_mask;
      end
    end
  end
endmodule

// File: rtl/ham_sector_corrector_chk.sv
module ham_sector_corrector_chk
  import ham_ecc_pkg::*;
(
  input logic                clk,
  input logic                rst,
  input logic                start,
  input logic                done,
  input logic [1:0]          status,
  input logic [IDX_W-1:0]    fix_byte,
  input logic [7:0]          fix_mask,
  input logic                ev_pair,
  input logic                ev_single,
  input logic                ev_clean
);
  // R7
  done_follows_start_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> done);
  // R7
  done_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(start));
  // R8
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (!done && status == 2'd0));
  // R3
  fix_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    (done && status == 2'd1) |-> $countones(fix_mask) == 1);
  // R9
  no_location_chk: assert property (@(posedge clk) disable iff (rst)
    (done && status != 2'd1) |-> (fix_mask == '0 && fix_byte == '0));
  // R4
  single_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (start && ev_single) |=> status == 2'd2);
  // R2
  clean_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (start && ev_clean) |=> status == 2'd0);
  // R3
  pair_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (start && ev_pair) |=> status == 2'd1);
endmodule

bind ham_sector_corrector ham_sector_corrector_chk u_chk (
  .clk(clk), .rst(rst), .start(start), .done(done), .status(status),
  .fix_byte(fix_byte), .fix_mask(fix_mask),
  .ev_pair(ev_pair), .ev_single(ev_single), .ev_clean(ev_clean)
);

// File: tb/ham_sector_corrector_tb.sv
module ham_sector_corrector_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [23:0] stored_code = '0;
  logic [23:0] calc_code = '0;
  logic        done;
  logic [1:0]  status;
  logic [8:0]  fix_byte;
  logic [7:0]  fix_mask;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  ham_sector_corrector u_dut (
    .clk(clk), .rst(rst), .start(start), .stored_code(stored_code),
    .calc_code(calc_code), .done(done), .status(status),
    .fix_byte(fix_byte), .fix_mask(fix_mask)
  );

  // Bench model: the word layout written directly from the requirement text.
  function automatic logic [31:0] tb_word(input logic [23:0] c);
    return {4'h0, c[23:20], c[15:8], 4'h0, c[19:16], c[7:0]};
  endfunction
  // Inverse layout: 3-byte code from a word.
  function automatic logic [23:0] tb_code(input logic [31:0] w);
    return {w[27:24], w[11:8], w[23:16], w[7:0]};
  endfunction
  function automatic int tb_ones(input logic [31:0] w);
    int n = 0;
    for (int i = 0; i < 32; i++) if (w[i]) n++;
    return n;
  endfunction

  logic [1:0] e_st;
  logic [8:0] e_byte;
  logic [7:0] e_mask;
  string      e_req;

  task automatic predict(input logic [23:0] s, input logic [23:0] c);
    logic [31:0] sy;
    int          w;
    sy = tb_word(s) ^ tb_word(c);
    w  = tb_ones(sy);
    e_byte = '0; e_mask = '0;
    if (sy == 0) begin e_st = 0; e_req = "R2/R9"; end
    else if (w == 12) begin
      e_st = 1; e_byte = sy[27:19]; e_mask = 8'h01 << sy[18:16]; e_req = "R1/R3";
    end else if (w == 1) begin e_st = 2; e_req = "R4/R9"; end
    else if (tb_word(s) == 32'h0FFF0FFF && tb_word(c) == 0) begin e_st = 0; e_req = "R5/R1"; end
    else begin e_st = 3; e_req = "R6/R9"; end
  endtask

  task automatic check(input string req, input bit cond, input string msg);
    n_tests++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  // Drive one sector at a negedge and check the verdict one negedge later.
  // With keep_start the next sector follows immediately (R7 back-to-back).
  logic [1:0] p_st; logic [8:0] p_byte; logic [7:0] p_mask; string p_req; bit p_valid = 0;

  task automatic step(input bit go, input logic [23:0] s, input logic [23:0] c);
    @(negedge clk);
    if (p_valid) begin
      check("R7", done === 1'b1, $sformatf("done act=%0b exp=1", done));
      check(p_req, status === p_st && fix_byte === p_byte && fix_mask === p_mask,
        $sformatf("act st=%0d byte=%0d mask=%02h exp st=%0d byte=%0d mask=%02h",
          status, fix_byte, fix_mask, p_st, p_byte, p_mask));
    end else begin
      check("R7", done === 1'b0, $sformatf("idle done act=%0b exp=0", done));
    end
    start = go; stored_code = s; calc_code = c;
    if (go) begin
      predict(s, c);
      p_st = e_st; p_byte = e_byte; p_mask = e_mask; p_req = e_req;
    end
    p_valid = go;
  endtask

  function automatic logic [23:0] pair_flip(input logic [8:0] b, input logic [2:0] k);
    logic [11:0] p;
    p = {b, k};
    return tb_code({4'h0, p[11:0], 4'h0, ~p}) ;
  endfunction

  function automatic logic [23:0] pair_code(input logic [8:0] b, input logic [2:0] k);
    logic [11:0] p;
    logic [31:0] w;
    p = {b, k};
    w = '0;
    w[27:16] = p;
    w[11:0]  = ~p;
    return tb_code(w);
  endfunction

  initial begin
    #1_000_000;
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: act=timeout exp=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [23:0] s, c;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R8", done === 1'b0 && status === 2'd0,
      $sformatf("reset act done=%0b st=%0d exp 0/0", done, status));
    rst = 1'b0;

    // Directed corners
    step(1, 24'h123456, 24'h123456);                 // R2 clean
    step(1, 24'hFFFFFF, 24'h000000);                 // R5 erased
    step(0, 0, 0);
    step(1, 24'hA5A5A5, 24'hA5A5A5 ^ pair_code(9'd0, 3'd0));    // R3 low corner
    step(1, 24'h0F0F0F, 24'h0F0F0F ^ pair_code(9'd511, 3'd7));  // R3 high corner
    step(1, 24'h000001, 24'h000000);                 // R4
    step(1, 24'h100000, 24'h000000);                 // R4 high nibble
    step(1, 24'hFFFFFF, 24'h000001);                 // R6 near-erased
    step(1, 24'h000003, 24'h000000);                 // R6 weight 2
    step(0, 0, 0);

    // Bursts mixing classes back to back (R7)
    for (int i = 0; i < 400; i++) begin
      int kind;
      kind = $urandom_range(0, 4);
      s = 24'($urandom);
      case (kind)
        0: c = s;
        1: c = s ^ pair_code(9'($urandom_range(0, 511)), 3'($urandom_range(0, 7)));
        2: c = s ^ (24'h1 << $urandom_range(0, 23));
        3: begin s = 24'hFFFFFF; c = 24'h0; end
        default: c = 24'($urandom);
      endcase
      step(($urandom_range(0, 5) != 0), s, c);
    end
    step(0, 0, 0);

    // Mid-run reset (R8)
    step(1, 24'h000001, 24'h000000);
    @(negedge clk);
    rst = 1'b1; start = 1'b0; p_valid = 0;
    @(negedge clk);
    check("R8", done === 1'b0 && status === 2'd0,
      $sformatf("mid reset act done=%0b st=%0d exp 0/0", done, status));
    rst = 1'b0;
    step(0, 0, 0);
    step(0, 0, 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule